// File: doc/BRIEF.md
# Chainable Serial Track Word Slave

This block turns the five bits of an absolute track reader into a serial word for a synchronous serial interface (SSI) master. The master drives a clock that rests high between frames. After the clock has rested longer than a set timeout, the block latches a word built from the track inputs at the first falling clock edge. It then presents one bit, most significant first, at each rising edge. While it shifts, it takes in the data line of the device ahead of it in the chain. Once its own bits are out, it passes that upstream stream on, so a chain of readers behaves as one long shift register.

A 2-bit select chooses the word format. Select 11 gives a 5-bit Gray word, and can add a sixth, active-low lamp fault bit. Select 10 gives a 5-bit binary word. Selects 01 and 00 belong to the synchronized multi-reader modes, which another block handles; here they keep the data output quiet. A direction control flips the MSB, and an invert control flips every track bit. All of these inputs are read on a fast system clock that oversamples the SSI lines. The block has three states:
- `ST_IDLE` waits for a falling edge.
- `ST_SHIFT` shifts data.
- `ST_MUTE` keeps the output high through a frame in a synchronized mode.

The transitions are:
- T_LOAD: `ST_IDLE` to `ST_SHIFT` on a falling edge with select 11 or 10.
- T_MUTE: `ST_IDLE` to `ST_MUTE` on a falling edge with select 01 or 00.
- T_EXPIRE: `ST_SHIFT` or `ST_MUTE` back to `ST_IDLE` when the idle timer runs out with no edge in that cycle.

Top module: `ssi_chain_slave`

## Requirements
- R1: After reset, and whenever the block is idle, `sdo_o` is 1.
- R2: The first falling edge of `sclk_i` after idle latches the word. Each later rising edge makes `sdo_o` present the next bit, MSB first, within 4 system clocks. Between rising edges `sdo_o` holds.
- R3: With select 11 and `err_en_i` low, the word is the 5 polarity-adjusted track bits as they are (Gray), `track_i[4]` first.
- R4: With select 11 and `err_en_i` high, a sixth bit follows the track bits. It is 0 when `lamp_fault_i` is 1 and 1 otherwise.
- R5: `dir_rev_i`=1 inverts only the MSB. `inv_all_i`=1 inverts all five bits. With both set, every bit except the MSB is inverted.
- R6: With select 10, the word is the binary value of the polarity-adjusted Gray bits: b4=g4, bi=b(i+1) xor gi. It is always 5 bits long, and `err_en_i` has no effect.
- R7: After its own word, the block presents the `sdi_i` values it captured at falling edges 2, 3 and so on. The upstream word therefore follows its own word bit for bit.
- R8: With select 10, the `sdi_i` values captured at the falling edges after the first and second rising edges are discarded, and 0 is presented in their place.
- R9: With select 01 or 00, `sdo_o` stays 1 for the whole frame.
- R10: Every `sclk_i` edge restarts the idle timer. Once `TIMEOUT_CYC` system clocks pass without an edge, the frame ends, `sdo_o` returns to 1, and the next falling edge latches fresh track values.
- R11: Changes on the track inputs after the latching edge do not alter the word being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SSI clock from the master, high at rest |
| sdi_i | input | 1 | Serial data from the preceding device |
| sdo_o | output | 1 | Serial data toward the master or next device |
| track_i | input | TRACKS | Track bits, index 4 is the MSB |
| mode_i | input | 2 | Format select: 11 Gray, 10 binary, 01/00 synchronized (muted) |
| dir_rev_i | input | 1 | 1 inverts the MSB |
| inv_all_i | input | 1 | 1 inverts all track bits |
| err_en_i | input | 1 | 1 appends the lamp fault bit in Gray format |
| lamp_fault_i | input | 1 | 1 reports a lamp fault |

## Verification
Every fault in the state or the shift path surfaces on `sdo_o` at a known position in the stream. A load that fires at the wrong time, or a wrong length, shifts the boundary between the block's own bits and the upstream bits, so the first mismatch appears within one word of the frame start. A timer that fails to restart ends a frame early, and `sdo_o` goes high in the middle of the bitstream. The bench chains two instances behind a model master and compares every sampled bit with a queue of expected bits.

// File: rtl/ssi_chain_pkg.sv
package ssi_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_MUTE  = 2'd2
    } fsm_state_e;

    localparam logic [1:0] SEL_GRAY = 2'b11;
    localparam logic [1:0] SEL_BIN  = 2'b10;
    localparam logic [1:0] SEL_SYNC = 2'b01;
    localparam logic [1:0] SEL_SSI  = 2'b00;

endpackage

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);
    // clock pipe carries one extra stage to hold the previous value
    logic [STAGES:0]   sclk_pipe;
    logic [STAGES-1:0] sdi_pipe;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_pipe <= '1;
            sdi_pipe  <= '1;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-1:0], sclk_i};
            sdi_pipe  <= {sdi_pipe[STAGES-2:0], sdi_i};
        end
    end

    assign rise_o = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES];
    assign fall_o = ~sclk_pipe[STAGES-1] & sclk_pipe[STAGES];
    assign sdi_o  = sdi_pipe[STAGES-1];

endmodule

// File: rtl/ssi_idle_timer.sv
module ssi_idle_timer #(
    parameter int TIMEOUT_CYC = 2500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= LIMIT;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == LIMIT);

    // R10: an edge always rearms the timer
    a_r10_restart_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !expired_o);

endmodule

// File: rtl/ssi_word_former.sv
module ssi_word_former #(
    parameter int TRACKS = 5,
    parameter int LEN_W  = $clog2(TRACKS + 2)
) (
    input  logic [TRACKS-1:0] track_i,
    input  logic              dir_rev_i,
    input  logic              inv_all_i,
    input  logic              bin_i,
    input  logic              err_en_i,
    input  logic              lamp_fault_i,
    output logic [TRACKS:0]   word_o,
    output logic [LEN_W-1:0]  len_o
);
    logic [TRACKS-1:0] pol;
    logic [TRACKS-1:0] bin;

    always_comb begin
        pol = track_i ^ {TRACKS{inv_all_i}};
        pol[TRACKS-1] = pol[TRACKS-1] ^ dir_rev_i;
    end

    assign bin[TRACKS-1] = pol[TRACKS-1];
    generate
        for (genvar i = TRACKS - 2; i >= 0; i--) begin : g_g2b
            assign bin[i] = bin[i+1] ^ pol[i];
        end
    endgenerate

    always_comb begin
        if (bin_i) begin
            word_o = {1'b0, bin};
            len_o  = LEN_W'(TRACKS);
        end else if (err_en_i) begin
            word_o = {pol, ~lamp_fault_i};
            len_o  = LEN_W'(TRACKS + 1);
        end else begin
            word_o = {1'b0, pol};
            len_o  = LEN_W'(TRACKS);
        end
    end

endmodule

// File: rtl/ssi_chain_slave.sv
module ssi_chain_slave
    import ssi_chain_pkg::*;
#(
    parameter int TRACKS      = 5,
    parameter int TIMEOUT_CYC = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic [TRACKS-1:0] track_i,
    input  logic [1:0]        mode_i,
    input  logic              dir_rev_i,
    input  logic              inv_all_i,
    input  logic              err_en_i,
    input  logic              lamp_fault_i
);
    localparam int REG_W = TRACKS + 1;
    localparam int LEN_W = $clog2(TRACKS + 2);

    logic              rise, fall, sdi_s, expired;
    logic [REG_W-1:0]  word;
    logic [LEN_W-1:0]  word_len;

    fsm_state_e        state_q, state_d;
    logic [REG_W-1:0]  sr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  out_idx;
    logic              bin_q;
    logic [1:0]        rcnt_q;
    logic              sdo_q;
    logic              take_sdi;
    logic              fmt_ok;

    ssi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sclk_i (sclk_i),
        .sdi_i  (sdi_i),
        .rise_o (rise),
        .fall_o (fall),
        .sdi_o  (sdi_s)
    );

    ssi_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (rise | fall),
        .expired_o (expired)
    );

    ssi_word_former #(.TRACKS(TRACKS), .LEN_W(LEN_W)) u_word (
        .track_i      (track_i),
        .dir_rev_i    (dir_rev_i),
        .inv_all_i    (inv_all_i),
        .bin_i        (mode_i == SEL_BIN),
        .err_en_i     (err_en_i),
        .lamp_fault_i (lamp_fault_i),
        .word_o       (word),
        .len_o        (word_len)
    );

    assign fmt_ok   = (mode_i == SEL_GRAY) || (mode_i == SEL_BIN);
    assign out_idx  = len_q - LEN_W'(1);
    // in binary format the captures after rising edges 1 and 2 are dropped
    assign take_sdi = !(bin_q && (rcnt_q == 2'd1 || rcnt_q == 2'd2));

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) state_d = fmt_ok ? ST_SHIFT : ST_MUTE;   // T_LOAD / T_MUTE
            end
            ST_SHIFT, ST_MUTE: begin
                if (expired && !rise && !fall) state_d = ST_IDLE;  // T_EXPIRE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and shift path
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q   <= '0;
            len_q  <= LEN_W'(TRACKS);
            bin_q  <= 1'b0;
            rcnt_q <= 2'd0;
            sdo_q  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sdo_q <= 1'b1;
                    if (fall) begin
                        sr_q   <= word;
                        len_q  <= word_len;
                        bin_q  <= (mode_i == SEL_BIN);
                        rcnt_q <= 2'd0;
                    end
                end
                ST_SHIFT: begin
                    if (rise) begin
                        sdo_q <= sr_q[out_idx];
                        if (rcnt_q != 2'd3) rcnt_q <= rcnt_q + 2'd1;
                    end
                    if (fall) begin
                        sr_q <= {sr_q[REG_W-2:0], take_sdi ? sdi_s : 1'b0};
                    end
                end
                ST_MUTE: begin
                    sdo_q <= 1'b1;
                end
                default: sdo_q <= 1'b1;
            endcase
        end
    end

    assign sdo_o = sdo_q;

    // R1: output rests high once idle
    a_r1_idle_output_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |=> sdo_o);

    // R9: muted frames keep the line high
    a_r9_mute_output_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_MUTE) |-> sdo_o);

    // R2: data only moves on a rising edge
    a_r2_hold_between_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SHIFT && !rise) |=> $stable(sdo_o));

    // R6: binary frames never carry the sixth bit
    a_r6_binary_five_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SHIFT && bin_q) |-> (len_q == LEN_W'(TRACKS)));

endmodule

// File: tb/ssi_chain_slave_tb_top.sv
module ssi_chain_slave_tb_top;

    localparam int HALF = 8;
    localparam int TOUT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic a_sdo, b_sdo;

    logic [4:0] a_tr = '0, b_tr = '0;
    logic [1:0] a_mode = 2'b11, b_mode = 2'b11;
    logic a_dir = 0, a_inv = 0, a_err = 0, a_fault = 0;
    logic b_dir = 0, b_inv = 0, b_err = 0, b_fault = 0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic  exp_q[$];
    string tag_q[$];
    event  smp_ev;

    always #4 clk = ~clk;

    ssi_chain_slave #(.TIMEOUT_CYC(TOUT)) up_i (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(1'b1), .sdo_o(a_sdo),
        .track_i(a_tr), .mode_i(a_mode), .dir_rev_i(a_dir), .inv_all_i(a_inv),
        .err_en_i(a_err), .lamp_fault_i(a_fault)
    );

    ssi_chain_slave #(.TIMEOUT_CYC(TOUT)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(a_sdo), .sdo_o(b_sdo),
        .track_i(b_tr), .mode_i(b_mode), .dir_rev_i(b_dir), .inv_all_i(b_inv),
        .err_en_i(b_err), .lamp_fault_i(b_fault)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sdo actual %b expected %b", tag, act, exp);
        end
    endtask

    // expected word per requirements R3..R6
    function automatic logic [5:0] exp_word(input logic [4:0] tr, input logic dir,
            input logic inv, input logic [1:0] md, input logic err, input logic fault,
            output int len);
        logic [4:0] g, b;
        g = tr;
        for (int i = 0; i < 5; i++) if (inv) g[i] = ~g[i];
        if (dir) g[4] = ~g[4];
        b[4] = g[4];
        for (int i = 3; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        if (md == 2'b10) begin len = 5; return {1'b0, b}; end
        if (err) begin len = 6; return {g, ~fault}; end
        len = 5;
        return {1'b0, g};
    endfunction

    // driver: push expected stream, then clock the chain
    task automatic frame(input string own_tag, input bit chg, input logic [4:0] new_tr);
        int lb, la, nb;
        logic [5:0] wb, wa;
        bit a_muted, b_muted;
        wb = exp_word(b_tr, b_dir, b_inv, b_mode, b_err, b_fault, lb);
        wa = exp_word(a_tr, a_dir, a_inv, a_mode, a_err, a_fault, la);
        a_muted = (a_mode == 2'b01 || a_mode == 2'b00);
        b_muted = (b_mode == 2'b01 || b_mode == 2'b00);
        nb = lb + la + 2;
        for (int k = 0; k < nb; k++) begin
            if (b_muted) begin
                exp_q.push_back(1'b1); tag_q.push_back("R9");
            end else if (k < lb) begin
                exp_q.push_back(wb[lb-1-k]); tag_q.push_back(own_tag);
            end else begin
                int j = k - lb;
                if (b_mode == 2'b10 && j < 2) begin
                    exp_q.push_back(1'b0); tag_q.push_back("R8");
                end else begin
                    exp_q.push_back((a_muted || j >= la) ? 1'b1 : wa[la-1-j]);
                    tag_q.push_back("R7");
                end
            end
        end
        for (int k = 0; k < nb; k++) begin
            @(negedge clk); sclk = 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            if (chg && k == 2) b_tr = new_tr;
            repeat (HALF) @(negedge clk);
            -> smp_ev;
        end
        repeat (3 * TOUT) @(negedge clk);
        check_bit("R10 idle after frame", b_sdo, 1'b1);
    endtask

    // monitor: compare each sample against the scoreboard
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                check_bit("R7 unexpected sample", b_sdo, 1'bx);
            end else begin
                check_bit(tag_q.pop_front(), b_sdo, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check_bit("R1 reset", b_sdo, 1'b1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 + R7: plain Gray words through the chain
        a_tr = 5'b10110; b_tr = 5'b01101;
        frame("R3", 0, '0);
        a_tr = 5'b01011; b_tr = 5'b11000;
        frame("R3", 0, '0);

        // R4: lamp bit present and active low
        b_err = 1; b_fault = 1; b_tr = 5'b10011;
        frame("R4", 0, '0);
        b_fault = 0;
        frame("R4", 0, '0);
        b_err = 0;

        // R5: polarity controls
        b_tr = 5'b00101; b_dir = 1;
        frame("R5", 0, '0);
        b_dir = 0; b_inv = 1;
        frame("R5", 0, '0);
        b_dir = 1;
        frame("R5", 0, '0);
        b_dir = 0; b_inv = 0;

        // R6 + R8: binary format, error enable ignored, upstream bits dropped
        a_tr = 5'b11010; b_mode = 2'b10; b_err = 1; b_tr = 5'b01110;
        frame("R6", 0, '0);
        b_inv = 1; b_tr = 5'b10001;
        frame("R6", 0, '0);
        b_inv = 0; b_err = 0;

        // R9: synchronized selects keep output high
        b_mode = 2'b01;
        frame("R9", 0, '0);
        b_mode = 2'b00;
        frame("R9", 0, '0);
        b_mode = 2'b11;

        // R11: track change mid frame has no effect; R10: next frame reloads
        b_tr = 5'b10101;
        frame("R11", 1, 5'b01010);
        frame("R10", 0, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule